// File: doc/BRIEF.md
# Write-Once Power Configuration Lock Register

This block holds an 8-bit lock register on a simple single-cycle register bus. The bus has an address, a write enable, write data and combinational read data. Three of its bits are write-once locks. Software can move each lock from 0 to 1, and only a platform reset returns it to 0. Each lock freezes one group of guarded configuration fields. The block keeps those guarded fields itself, so the gating can be observed at its own ports:

- a power-state configuration word and a timing register, frozen by lock bit 0;
- the base-address field of a base register, frozen by lock bit 1;
- a sleep-signal stretching word, frozen by lock bit 2.

Bit 7 is a sticky status flag that software can only read. Hardware sets it when a deep power-state transition pulse arrives while lock bit 0 is still clear. It records that the power-state configuration was left open when such a transition happened. The block also exports one write-permit signal per lock group, so that neighbouring register blocks can apply the same gating.

Top module: `pm_lock_reg`

## Requirements
- R1: After platform reset (rstN low) every register reads 0000h, and permit reads 3'b111.
- R2: Writing the lock register at address A6h sets each lock bit 2..0 whose data bit is 1. A 0 in the data never clears a lock bit that is already set.
- R3: Bits 6:3 of the lock register always read 0. Writes to bits 7:3 of the lock register change nothing.
- R4: While lock bit 0 is set, writes to the configuration word at 44h and to the timing register at 48h are dropped. The configuration word holds bit 0 mode-enable, bit 1 deep-state-disable and bits 3:2 PLL lock time. The timing register is bits 7:0.
- R5: While lock bit 1 is set, writes to the base field (bits 15:7) of the base register at 40h are dropped. The other bits of that register read 0.
- R6: While lock bit 2 is set, writes to the stretch word at 4Ch are dropped. The stretch word holds bits 1:0 minimum assertion width and bits 4:2 three stretch enables.
- R7: A deepEvt pulse sets bit 7 on the next clock if lock bit 0 was clear before that edge. This holds even when the same cycle writes 1 to lock bit 0. A pulse that arrives while lock bit 0 is already set leaves bit 7 unchanged.
- R8: Once set, bit 7 holds until platform reset.
- R9: permit[i] is the inverse of lock bit i. It changes on the clock edge that stores the lock write, so the first guarded write after that edge is already dropped.
- R10: Reads from an address that is not mapped return 0000h, and writes to such an address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Platform reset, active low, asynchronous |
| addr | input | 8 | Register byte address |
| wrEn | input | 1 | Single-cycle write strobe |
| wrData | input | 16 | Write data |
| deepEvt | input | 1 | One-cycle pulse marking a power-state transition deeper than C2 |
| rdData | output | 16 | Combinational read data for addr |
| permit | output | 3 | Per-group write permission, bit i = not lock bit i |

## Verification
A deep-transition pulse and a software write that sets lock bit 0 can fall in the same cycle. In that case the status bit must follow the lock value from before the edge. The bench drives deepEvt high during the very write that sets bit 0, then reads the lock register and expects both bit 7 and bit 0 set. After a fresh reset it sets bit 0 first and then pulses deepEvt. There it expects bit 7 to stay clear, which separates sampling of the old lock value from sampling of the new one.

// File: rtl/pm_lock_pkg.sv
`timescale 1ns/1ps
package pm_lock_pkg;

  // lock bit positions: neighbours decode these, so the order is fixed
  localparam int NUM_LOCKS = 3;
  localparam int LOCK_CFG  = 0;
  localparam int LOCK_BASE = 1;
  localparam int LOCK_STR  = 2;

  // guarded field widths
  localparam int CFG_W     = 4;   // {pllTime[1:0], deepDis, modeEn}
  localparam int PLL_W     = 2;
  localparam int MINW_W    = 2;
  localparam int STREN_W   = 3;
  localparam int STR_W     = MINW_W + STREN_W;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_LOCK = 3'd1,
    SEL_BASE = 3'd2,
    SEL_CFG  = 3'd3,
    SEL_TIM  = 3'd4,
    SEL_STR  = 3'd5
  } rdSel_t;

  typedef struct packed {
    rdSel_t rdSel;
    logic   lockWr;
    logic   baseWr;
    logic   cfgWr;
    logic   timWr;
    logic   strWr;
  } pmStrobes_t;

endpackage

// File: rtl/pm_lock_ctrl.sv
`timescale 1ns/1ps
module pm_lock_ctrl
  import pm_lock_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'hA6,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 8'h44,
  parameter logic [ADDR_W-1:0] TIM_ADDR  = 8'h48,
  parameter logic [ADDR_W-1:0] STR_ADDR  = 8'h4C
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wrEn,
  input  logic [NUM_LOCKS-1:0] lockBits,
  input  logic                 deepEvt,
  output pmStrobes_t           stb,
  output logic [NUM_LOCKS-1:0] lockQ,
  output logic                 statusQ,
  output logic [NUM_LOCKS-1:0] permit
);

  rdSel_t hitSel;

  // address decode
  always_comb begin
    hitSel = SEL_NONE;
    if      (addr == LOCK_ADDR) hitSel = SEL_LOCK;
    else if (addr == BASE_ADDR) hitSel = SEL_BASE;
    else if (addr == CFG_ADDR)  hitSel = SEL_CFG;
    else if (addr == TIM_ADDR)  hitSel = SEL_TIM;
    else if (addr == STR_ADDR)  hitSel = SEL_STR;
  end

  assign permit = ~lockQ;

  // strobe generation, guarded writes gated by the current lock state
  always_comb begin
    stb        = '0;
    stb.rdSel  = hitSel;
    stb.lockWr = wrEn && (hitSel == SEL_LOCK);
    stb.baseWr = wrEn && (hitSel == SEL_BASE) && permit[LOCK_BASE];
    stb.cfgWr  = wrEn && (hitSel == SEL_CFG)  && permit[LOCK_CFG];
    stb.timWr  = wrEn && (hitSel == SEL_TIM)  && permit[LOCK_CFG];
    stb.strWr  = wrEn && (hitSel == SEL_STR)  && permit[LOCK_STR];
  end

  // write-once lock bank
  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
    logic bitQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                           bitQ <= 1'b0;
      else if (stb.lockWr && lockBits[i])  bitQ <= 1'b1;
    end
    assign lockQ[i] = bitQ;

    assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
      lockQ[i] |=> lockQ[i]);
    assert_lock_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == LOCK_ADDR && lockBits[i]) |=> lockQ[i]);
  end

  // sticky deep-transition status, samples the pre-edge lock value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               statusQ <= 1'b0;
    else if (deepEvt && !lockQ[LOCK_CFG])    statusQ <= 1'b1;
  end

  assert_status_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (deepEvt && !lockQ[LOCK_CFG]) |=> statusQ);
  assert_status_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!statusQ && (!deepEvt || lockQ[LOCK_CFG])) |=> !statusQ);
  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    statusQ |=> statusQ);
  assert_guard_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.lockWr, stb.baseWr, stb.cfgWr, stb.timWr, stb.strWr}));

endmodule

// File: rtl/pm_lock_dpath.sv
`timescale 1ns/1ps
module pm_lock_dpath
  import pm_lock_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int BASE_LSB   = 7,
  parameter int TIM_W      = 8,
  parameter int STATUS_BIT = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pmStrobes_t           stb,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_LOCKS-1:0] lockQ,
  input  logic                 statusQ,
  input  logic [NUM_LOCKS-1:0] permit,
  output logic [DATA_W-1:0]    rdData
);

  localparam int BASE_W = DATA_W - BASE_LSB;

  logic [BASE_W-1:0]  baseQ;
  logic               modeEnQ;
  logic               deepDisQ;
  logic [PLL_W-1:0]   pllTimeQ;
  logic [TIM_W-1:0]   timQ;
  logic [MINW_W-1:0]  minWidthQ;
  logic [STREN_W-1:0] strEnQ;

  // base-address field
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           baseQ <= '0;
    else if (stb.baseWr) baseQ <= wrData[DATA_W-1:BASE_LSB];
  end

  // power-state configuration fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeEnQ  <= 1'b0;
      deepDisQ <= 1'b0;
      pllTimeQ <= '0;
    end else if (stb.cfgWr) begin
      modeEnQ  <= wrData[0];
      deepDisQ <= wrData[1];
      pllTimeQ <= wrData[CFG_W-1:2];
    end
  end

  // timing register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          timQ <= '0;
    else if (stb.timWr) timQ <= wrData[TIM_W-1:0];
  end

  // stretching policy fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      minWidthQ <= '0;
      strEnQ    <= '0;
    end else if (stb.strWr) begin
      minWidthQ <= wrData[MINW_W-1:0];
      strEnQ    <= wrData[STR_W-1:MINW_W];
    end
  end

  // read mux
  always_comb begin
    rdData = '0;
    case (stb.rdSel)
      SEL_LOCK: begin
        rdData[STATUS_BIT]     = statusQ;
        rdData[NUM_LOCKS-1:0]  = lockQ;
      end
      SEL_BASE: rdData[DATA_W-1:BASE_LSB] = baseQ;
      SEL_CFG:  rdData[CFG_W-1:0]         = {pllTimeQ, deepDisQ, modeEnQ};
      SEL_TIM:  rdData[TIM_W-1:0]         = timQ;
      SEL_STR:  rdData[STR_W-1:0]         = {strEnQ, minWidthQ};
      default:  rdData = '0;
    endcase
  end

  assert_cfg_frozen_R4: assert property (@(posedge clk) disable iff (!rstN)
    !permit[LOCK_CFG] |=> ($stable(modeEnQ) && $stable(deepDisQ) && $stable(pllTimeQ)));
  assert_tim_frozen_R4: assert property (@(posedge clk) disable iff (!rstN)
    !permit[LOCK_CFG] |=> $stable(timQ));
  assert_base_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    !permit[LOCK_BASE] |=> $stable(baseQ));
  assert_str_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    !permit[LOCK_STR] |=> ($stable(minWidthQ) && $stable(strEnQ)));

endmodule

// File: rtl/pm_lock_reg.sv
`timescale 1ns/1ps
module pm_lock_reg
  import pm_lock_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 16,
  parameter int                BASE_LSB   = 7,
  parameter int                TIM_W      = 8,
  parameter int                STATUS_BIT = 7,
  parameter logic [ADDR_W-1:0] LOCK_ADDR  = 8'hA6,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 8'h40,
  parameter logic [ADDR_W-1:0] CFG_ADDR   = 8'h44,
  parameter logic [ADDR_W-1:0] TIM_ADDR   = 8'h48,
  parameter logic [ADDR_W-1:0] STR_ADDR   = 8'h4C
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wrEn,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 deepEvt,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_LOCKS-1:0] permit
);

  pmStrobes_t           stb;
  logic [NUM_LOCKS-1:0] lockQ;
  logic                 statusQ;

  pm_lock_ctrl #(
    .ADDR_W   (ADDR_W),
    .LOCK_ADDR(LOCK_ADDR),
    .BASE_ADDR(BASE_ADDR),
    .CFG_ADDR (CFG_ADDR),
    .TIM_ADDR (TIM_ADDR),
    .STR_ADDR (STR_ADDR)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .wrEn    (wrEn),
    .lockBits(wrData[NUM_LOCKS-1:0]),
    .deepEvt (deepEvt),
    .stb     (stb),
    .lockQ   (lockQ),
    .statusQ (statusQ),
    .permit  (permit)
  );

  pm_lock_dpath #(
    .DATA_W    (DATA_W),
    .BASE_LSB  (BASE_LSB),
    .TIM_W     (TIM_W),
    .STATUS_BIT(STATUS_BIT)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (wrData),
    .lockQ  (lockQ),
    .statusQ(statusQ),
    .permit (permit),
    .rdData (rdData)
  );

endmodule

// File: tb/pm_lock_reg_bench.sv
`timescale 1ns/1ps
module pm_lock_reg_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        deepEvt = 1'b0;
  logic [15:0] rdData;
  logic [2:0]  permit;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [15:0] rdExp;
    logic [2:0]  permExp;
    string       tag;
  } item_t;

  item_t pend[$];

  always #10 clk = ~clk;   // 50 MHz

  pm_lock_reg u_pm_lock_reg (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .deepEvt(deepEvt), .rdData(rdData), .permit(permit)
  );

  // driver tasks: each occupies exactly one clock cycle
  task automatic cyc(input logic [7:0] a, input logic we, input logic [15:0] d, input logic ev);
    @(posedge clk); #1;
    addr = a; wrEn = we; wrData = d; deepEvt = ev;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    cyc(a, 1'b1, d, 1'b0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] e, input logic [2:0] p, input string t);
    item_t it;
    cyc(a, 1'b0, 16'h0000, 1'b0);
    it.rdExp = e; it.permExp = p; it.tag = t;
    pend.push_back(it);
  endtask

  task automatic doReset();
    @(posedge clk); #1;
    rstN = 1'b0; wrEn = 1'b0; deepEvt = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    rstN = 1'b1;
  endtask

  // monitor: compares each read cycle against the queued expectation
  always @(negedge clk) begin
    if (pend.size() > 0) begin
      item_t it;
      it = pend.pop_front();
      checks++;
      if (rdData !== it.rdExp) begin
        fails++;
        $display("FAIL %s rdData actual=%h expected=%h", it.tag, rdData, it.rdExp);
      end
      checks++;
      if (permit !== it.permExp) begin
        fails++;
        $display("FAIL %s permit actual=%b expected=%b", it.tag, permit, it.permExp);
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    rd(8'hA6, 16'h0000, 3'b111, "R1 lock reset");
    rd(8'h40, 16'h0000, 3'b111, "R1 base reset");
    rd(8'h44, 16'h0000, 3'b111, "R1 cfg reset");
    rd(8'h48, 16'h0000, 3'b111, "R1 tim reset");
    rd(8'h4C, 16'h0000, 3'b111, "R1 str reset");

    // unlocked writes
    wr(8'h40, 16'hFFFF); rd(8'h40, 16'hFF80, 3'b111, "R5 base field only");
    wr(8'h44, 16'hFFFF); rd(8'h44, 16'h000F, 3'b111, "R4 cfg unlocked");
    wr(8'h48, 16'h00A5); rd(8'h48, 16'h00A5, 3'b111, "R4 tim unlocked");
    wr(8'h4C, 16'hFFFF); rd(8'h4C, 16'h001F, 3'b111, "R6 str unlocked");

    // R3 reserved and status bits ignore writes
    wr(8'hA6, 16'h00F8); rd(8'hA6, 16'h0000, 3'b111, "R3 reserved write");

    // R10 unmapped address
    wr(8'h10, 16'hFFFF); rd(8'h10, 16'h0000, 3'b111, "R10 unmapped read");
    rd(8'h40, 16'hFF80, 3'b111, "R10 base untouched");

    // R2/R9 base lock
    wr(8'hA6, 16'h0002); rd(8'hA6, 16'h0002, 3'b101, "R2 set base lock");
    wr(8'h40, 16'h1234); rd(8'h40, 16'hFF80, 3'b101, "R5 base frozen");
    wr(8'h44, 16'h0005); rd(8'h44, 16'h0005, 3'b101, "R4 cfg still open");
    wr(8'hA6, 16'h0000); rd(8'hA6, 16'h0002, 3'b101, "R2 zero write no clear");

    // R7 event while cfg lock clear
    cyc(8'h00, 1'b0, 16'h0000, 1'b1);
    rd(8'hA6, 16'h0082, 3'b101, "R7 status set");

    // R4/R9 cfg lock: first guarded write right after the lock edge is dropped
    wr(8'hA6, 16'h0001);
    wr(8'h44, 16'h000A); rd(8'h44, 16'h0005, 3'b100, "R9 next-cycle write dropped");
    wr(8'h48, 16'h003C); rd(8'h48, 16'h00A5, 3'b100, "R4 tim frozen");
    wr(8'h4C, 16'h0003); rd(8'h4C, 16'h0003, 3'b100, "R6 str still open");

    // R6 stretch lock
    wr(8'hA6, 16'h0004); rd(8'hA6, 16'h0087, 3'b000, "R2 all locks");
    wr(8'h4C, 16'h001C); rd(8'h4C, 16'h0003, 3'b000, "R6 str frozen");
    wr(8'hA6, 16'h0080); rd(8'hA6, 16'h0087, 3'b000, "R8 status write ignored");
    cyc(8'h00, 1'b0, 16'h0000, 1'b1);
    rd(8'hA6, 16'h0087, 3'b000, "R8 status held");

    // platform reset clears all
    doReset();
    rd(8'hA6, 16'h0000, 3'b111, "R8 reset clears status");
    rd(8'h4C, 16'h0000, 3'b111, "R1 str reset again");

    // R7 event in the same cycle as the cfg lock write
    cyc(8'hA6, 1'b1, 16'h0001, 1'b1);
    rd(8'hA6, 16'h0081, 3'b110, "R7 same-cycle event and lock");

    // R7 event after cfg lock is already set
    doReset();
    wr(8'hA6, 16'h0001);
    cyc(8'h00, 1'b0, 16'h0000, 1'b1);
    rd(8'hA6, 16'h0001, 3'b110, "R7 event ignored when locked");

    cyc(8'h00, 1'b0, 16'h0000, 1'b0);
    @(posedge clk); #1;
    done = 1'b1;
    summary();
    $finish;
  end

endmodule